// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave on a two-wire bus (SMBus/I2C style). It lets a bus master read and write a small bank of byte-wide registers that live in the surrounding core logic. The SCL and SDA lines are first passed through a synchronizer and then sampled by a fast system clock. From those samples the block detects START, repeated START and STOP. It compares the 7-bit device address, captures a command byte that selects one register, and then carries out a Write Byte, a Read Byte or a Read Word transfer.

SDA comes in as a plain input. The block answers through an open-drain enable: when that enable is 1, the SDA line is pulled low. The core logic sees a parallel port made of a register index, a one-cycle write strobe with its data, and a read-data input that must return the indexed register combinationally.

The low five address bits come from three strap inputs. Each strap is an already-resolved three-level code. The register index persists between transactions, so a master can issue a bare read and get back the register it selected last. A Read Word returns that same register a second time; the index does not advance.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_wr` is 0 and `reg_addr` is 0.
- R2: The device address is the 7-bit value {1,0,a4..a0}, with a4..a0 = 9*s2 + 3*s1 + s0. Each strap digit sN is taken from its 2-bit code: 00 = low = 0, 01 = open = 1, 10 = high = 2, and 11 is treated as open. An address byte that matches is acknowledged by pulling SDA low for the ninth clock.
- R3: An address that does not match is not acknowledged. SDA stays released for the rest of that transaction, and no register is written.
- R4: The command byte is acknowledged. Its bits 2..0 become the register index and bits 7..3 are ignored.
- R5: In a write, the data byte that follows the command is acknowledged. It is presented on `reg_wdata` while `reg_wr` pulses, so it lands in the indexed register.
- R6: A repeated START followed by an address byte with R/W = 1 is acknowledged. The indexed register is then shifted out MSB first, and SDA changes only while SCL is low.
- R7: If the master acknowledges a read byte, the same register is sent again as the next byte.
- R8: A not-acknowledge from the master after a read byte makes the slave release SDA until the next START.
- R9: The register index keeps its value after STOP. A read that carries no command byte returns the register selected last.
- R10: A START in any state, including in the middle of a byte, restarts address reception. A STOP returns the slave to idle with SDA released.
- R11: `reg_wr` is a single-cycle pulse issued just after an SCL falling edge.
- R12: Any byte after the data byte of a write is neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap0_i | input | 2 | Address strap digit s0 code |
| strap1_i | input | 2 | Address strap digit s1 code |
| strap2_i | input | 2 | Address strap digit s2 code |
| reg_addr | output | PTR_W | Persistent register index |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Content of the indexed register |

## Verification
Most internal errors in this block show up on the bus within a single byte. A wrong bit count or a wrong state moves the acknowledge slot, so the master reads a NACK or a corrupted data bit on the very next ninth clock. A wrong command-byte decode or a lost register index shows up as a wrong byte on the following read, even one in a later transaction, which is why the bench makes bare reads after STOP. A slave that fails to release SDA is caught by clocking extra bytes after a NACK, after a mismatched address and after a write, and checking that the line reads high.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e        st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shift;
        logic              rw;
        logic              mack;
        logic              oe;
        logic              wr;
    } slv_core_t;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // index STAGES holds the previous synchronized sample
    logic [STAGES:0] scl_q, sda_q;
    logic scl_now, scl_prev, sda_now, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    assign scl_now  = scl_q[STAGES-1];
    assign scl_prev = scl_q[STAGES];
    assign sda_now  = sda_q[STAGES-1];
    assign sda_prev = sda_q[STAGES];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/smb_strap_addr.sv
module smb_strap_addr #(
    parameter int N_STRAP = 3,
    parameter int AW      = 5
) (
    input  logic [2*N_STRAP-1:0] strap_codes,
    output logic [AW-1:0]        dev_addr
);
    function automatic logic [AW-1:0] to_base3(input logic [2*N_STRAP-1:0] codes);
        int acc;
        int digit;
        acc = 0;
        for (int i = N_STRAP - 1; i >= 0; i--) begin
            digit = (codes[2*i +: 2] == 2'b11) ? 1 : int'(codes[2*i +: 2]);
            acc   = acc * 3 + digit;
        end
        return AW'(acc);
    endfunction

    always_comb dev_addr = to_base3(strap_codes);

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
    parameter logic [1:0] ADDR_PREFIX = 2'b10,
    parameter int         PTR_W       = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       strap0_i,
    input  logic [1:0]       strap1_i,
    input  logic [1:0]       strap2_i,
    output logic [PTR_W-1:0] reg_addr,
    output logic             reg_wr,
    output logic [7:0]       reg_wdata,
    input  logic [7:0]       reg_rdata
);
    import smb_pkg::*;

    localparam int DEV_AW  = 7 - $bits(ADDR_PREFIX);
    localparam int N_STRAP = 3;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DEV_AW-1:0] dev_addr;

    slv_core_t        c_d, c_q;
    logic [PTR_W-1:0] ptr_d, ptr_q;

    smb_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_strap_addr #(.N_STRAP(N_STRAP), .AW(DEV_AW)) i_strap (
        .strap_codes ({strap2_i, strap1_i, strap0_i}),
        .dev_addr    (dev_addr)
    );

    always_comb begin
        c_d    = c_q;
        c_d.wr = 1'b0;
        ptr_d  = ptr_q;
        if (stop_det) begin
            c_d.st = ST_IDLE;
            c_d.oe = 1'b0;
        end else if (start_det) begin
            c_d.st  = ST_ADDR;
            c_d.cnt = '0;
            c_d.oe  = 1'b0;
        end else begin
            case (c_q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && c_q.cnt != 4'd8) begin
                        c_d.shift = {c_q.shift[BYTE_W-2:0], sda_s};
                        c_d.cnt   = c_q.cnt + 4'd1;
                    end else if (scl_fall && c_q.cnt == 4'd8) begin
                        c_d.cnt = '0;
                        if (c_q.st == ST_ADDR) begin
                            if (c_q.shift[7:1] == {ADDR_PREFIX, dev_addr}) begin
                                c_d.rw = c_q.shift[0];
                                c_d.oe = 1'b1;
                                c_d.st = ST_ADDR_ACK;
                            end else begin
                                c_d.st = ST_IDLE;
                            end
                        end else if (c_q.st == ST_CMD) begin
                            ptr_d  = c_q.shift[PTR_W-1:0];
                            c_d.oe = 1'b1;
                            c_d.st = ST_CMD_ACK;
                        end else begin
                            c_d.wr = 1'b1;
                            c_d.oe = 1'b1;
                            c_d.st = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (c_q.rw) begin
                            c_d.shift = reg_rdata;
                            c_d.oe    = ~reg_rdata[7];
                            c_d.st    = ST_RDATA;
                        end else begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        c_d.st = ST_WDATA;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        c_d.st = ST_IDLE;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (c_q.cnt == 4'd7) begin
                            c_d.cnt = '0;
                            c_d.oe  = 1'b0;
                            c_d.st  = ST_RDATA_ACK;
                        end else begin
                            c_d.shift = {c_q.shift[BYTE_W-2:0], 1'b0};
                            c_d.oe    = ~c_q.shift[BYTE_W-2];
                            c_d.cnt   = c_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        c_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (c_q.mack) begin
                            c_d.shift = reg_rdata;
                            c_d.oe    = ~reg_rdata[7];
                            c_d.st    = ST_RDATA;
                        end else begin
                            c_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q   <= '{st: ST_IDLE, default: '0};
            ptr_q <= '0;
        end else begin
            c_q   <= c_d;
            ptr_q <= ptr_d;
        end
    end

    assign sda_oe    = c_q.oe;
    assign reg_wr    = c_q.wr;
    assign reg_wdata = c_q.shift;
    assign reg_addr  = ptr_q;

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic reg_wr
);
    // R11: write strobe lasts exactly one cycle
    p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R11: write strobe follows an SCL falling edge
    p_wr_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(scl_fall));

    // R6: the data line only changes after SCL fell or after a bus condition
    p_oe_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det));

    // R10: STOP releases the line
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10: START releases the line
    p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);
endmodule

bind smb_reg_slave smb_reg_slave_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [1:0] s0 = 2'b00, s1 = 2'b00, s2 = 2'b00;
    logic [2:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] regs [8];

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] <= 8'(8'h30 + i);
        end else if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
        end
    end

    smb_reg_slave i_smb_reg_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap0_i  (s0),
        .strap1_i  (s1),
        .strap2_i  (s2),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] a2, input logic [1:0] a1,
                                             input logic [1:0] a0, input logic rw);
        int d2, d1, d0;
        d2 = (a2 == 2'b11) ? 1 : int'(a2);
        d1 = (a1 == 2'b11) ? 1 : int'(a1);
        d0 = (a0 == 2'b11) ? 1 : int'(a0);
        return {2'b10, 5'(d2 * 9 + d1 * 3 + d0), rw};
    endfunction

    task automatic bus_start();
        wq(); m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        wq(); m_sda = b; wq(); scl = 1'b1; wq(); smp = sda_line; wq(); scl = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic rbyte(input logic m_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~m_ack, s);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 reg_wr", int'(reg_wr), 0);
        check("R1 reg_addr", int'(reg_addr), 0);
    endtask

    task automatic t_write_byte();
        logic a;
        bus_start();
        wbyte(addr_byte(s2, s1, s0, 1'b0), a); check("R2 address ack", int'(a), 1);
        wbyte(8'hF5, a);                      check("R4 command ack", int'(a), 1);
        wbyte(8'hA5, a);                      check("R5 data ack", int'(a), 1);
        @(negedge clk);
        check("R5 register written", int'(regs[5]), 8'hA5);
        wbyte(8'h11, a);                      check("R12 extra byte nack", int'(a), 0);
        bus_stop();
        check("R12 register unchanged", int'(regs[5]), 8'hA5);
        check("R4 index from low bits", int'(reg_addr), 5);
    endtask

    task automatic t_read_word();
        logic a;
        logic [7:0] d;
        bus_start();
        wbyte(addr_byte(s2, s1, s0, 1'b0), a); check("R2 ack before read", int'(a), 1);
        wbyte(8'h05, a);                      check("R4 command ack", int'(a), 1);
        bus_start();
        wbyte(addr_byte(s2, s1, s0, 1'b1), a); check("R6 read address ack", int'(a), 1);
        rbyte(1'b1, d);                       check("R6 first byte", int'(d), 8'hA5);
        rbyte(1'b0, d);                       check("R7 repeated byte", int'(d), 8'hA5);
        rbyte(1'b0, d);                       check("R8 released after nack", int'(d), 8'hFF);
        bus_stop();
    endtask

    task automatic t_ptr_persist();
        logic a;
        logic [7:0] d;
        bus_start();
        wbyte(addr_byte(s2, s1, s0, 1'b1), a); check("R9 bare read ack", int'(a), 1);
        rbyte(1'b0, d);                       check("R9 persisted index", int'(d), 8'hA5);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] wrong;
        wrong = addr_byte(s2, s1, s0, 1'b0) ^ 8'h02;
        bus_start();
        wbyte(wrong, a);   check("R3 mismatch nack", int'(a), 0);
        wbyte(8'h03, a);   check("R3 command ignored", int'(a), 0);
        wbyte(8'h77, a);   check("R3 data ignored", int'(a), 0);
        bus_stop();
        check("R3 no write", int'(regs[3]), 8'h33);
    endtask

    task automatic t_straps();
        logic a;
        logic [7:0] old_w;
        old_w = addr_byte(s2, s1, s0, 1'b0);
        s2 = 2'b10; s1 = 2'b01; s0 = 2'b00;
        bus_start(); wbyte(8'hAA, a);         check("R2 a=21 address", int'(a), 1); bus_stop();
        bus_start(); wbyte(old_w, a);         check("R2 old address refused", int'(a), 0); bus_stop();
        s2 = 2'b11; s1 = 2'b00; s0 = 2'b10;
        bus_start(); wbyte(8'h96, a);         check("R2 code 11 as open", int'(a), 1); bus_stop();
    endtask

    task automatic t_restart();
        logic a, s;
        logic [7:0] d;
        bus_start();
        wbyte(addr_byte(s2, s1, s0, 1'b0), a); check("R10 address ack", int'(a), 1);
        wbyte(8'h02, a);                      check("R10 command ack", int'(a), 1);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
        bus_start();
        wbyte(addr_byte(s2, s1, s0, 1'b1), a); check("R10 restart address ack", int'(a), 1);
        rbyte(1'b0, d);                       check("R10 read after restart", int'(d), 8'h32);
        bus_stop();
        @(negedge clk);
        check("R10 released after stop", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_byte();
        t_read_word();
        t_ptr_persist();
        t_mismatch();
        t_straps();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule